// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control half of a small microcoded processor. It keeps the most recently fetched instruction byte in an instruction register. The upper nibble of that byte is the opcode and the lower nibble is the parameter field. A 16-entry start-address table turns an opcode into the first micro-address of that instruction. From there a micro-program counter walks a 256-word by 32-bit micro store, and the current word is presented as the control word for the datapath.

Each microword carries four things: a two-bit sequencing operation, a four-bit condition selector, an eight-bit jump target and eighteen control bits. A microstep whose condition fails has its control bits zeroed and does no sequencing action; the counter just moves on. A fetch microword loads the incoming instruction byte, pulses the instruction-pointer advance strobe and jumps straight to the mapped start address. Any microword can do this, so instructions can chain without passing through the shared fetch routine at address 0.

Both tables are parameters, so each instance carries its own microprogram. All state changes on the rising edge of the control-phase clock. Reset is synchronous and active high.

Top module: `useq_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, the micro-program counter is 0. The opcode and parameter outputs are 0, and the control word shows micro store word 0.
- R2: The control word always shows the micro store word at the current micro-program counter. A step operation (bits [31:30] = 00) whose condition holds moves the counter up by one. The counter wraps from 255 to 0.
- R3: A fetch operation (bits [31:30] = 01) whose condition holds does three things. It raises the instruction-pointer advance strobe in that cycle. At the next edge it loads the instruction byte into the instruction register, and it moves the counter to the start-table entry indexed by the byte's upper nibble.
- R4: A jump operation (bits [31:30] = 10) whose condition holds moves the counter to the target field, bits [25:18].
- R5: A restart operation (bits [31:30] = 11) whose condition holds moves the counter to 0.
- R6: The condition field is bits [29:26]. Bits [29:27] pick the flag: 0 always true, 1 zero, 2 carry, 3 overflow, 4 negative, 5 to 7 always false. Bit [26] inverts the result. The flags input carries zero on bit 0, carry on bit 1, overflow on bit 2 and negative on bit 3.
- R7: When a microword's condition is false, control word bits [17:0] read 0 and bits [31:18] still show the word. The counter moves up by one, the advance strobe stays low and the instruction register keeps its value.
- R8: The parameter output is the low nibble of the instruction register. The first register selector is parameter bits [3:2], and the second is bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-phase clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_byte | input | 8 | Instruction byte from instruction memory |
| alu_flags | input | 4 | Flags {negative, overflow, carry, zero} |
| ctrl_word | output | 32 | Current microword with control bits gated by its condition |
| upc | output | 8 | Current micro-program counter |
| ip_inc | output | 1 | Instruction-pointer advance strobe (fetch taken) |
| opcode | output | 4 | Opcode held in the instruction register |
| param | output | 4 | Parameter field held in the instruction register |
| sel_a | output | 2 | First register selector |
| sel_b | output | 2 | Second register selector |

## Verification
The control word and the advance strobe belong to the same cycle as their microstep. They depend on the flags applied in that cycle, so they are checked against that cycle's inputs. The counter, opcode, parameter and selectors change one edge after the microstep that causes them. Each expected item therefore describes the outputs of one cycle. Inputs are driven just after a rising edge, and the monitor compares at the following falling edge. The walk covers taken and untaken conditions for every sequencing operation, inverted and constant-false selectors, the wrap from 255 and a reset in mid-program.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;

    localparam int UADDR_W      = 8;
    localparam int USTORE_DEPTH = 1 << UADDR_W;
    localparam int UWORD_W      = 32;
    localparam int OPC_W        = 4;
    localparam int PRM_W        = 4;
    localparam int INSTR_W      = OPC_W + PRM_W;
    localparam int MAP_DEPTH    = 1 << OPC_W;
    localparam int CTL_W        = 18;
    localparam int COND_W       = 4;
    localparam int SEL_W        = PRM_W / 2;
    localparam int FLAG_W       = 4;

    typedef enum logic [1:0] {
        SQ_STEP    = 2'b00,
        SQ_FETCH   = 2'b01,
        SQ_JUMP    = 2'b10,
        SQ_RESTART = 2'b11
    } seq_op_e;

    typedef struct packed {
        seq_op_e             op;
        logic [COND_W-1:0]   cond;
        logic [UADDR_W-1:0]  target;
        logic [CTL_W-1:0]    ctl;
    } uword_t;

    typedef struct packed {
        logic n;
        logic v;
        logic c;
        logic z;
    } alu_flags_t;

    // Selector in the upper three bits, inversion in the lowest bit.
    function automatic logic cond_met(logic [COND_W-1:0] cond, alu_flags_t f);
        logic raw;
        case (cond[COND_W-1:1])
            3'd0:    raw = 1'b1;
            3'd1:    raw = f.z;
            3'd2:    raw = f.c;
            3'd3:    raw = f.v;
            3'd4:    raw = f.n;
            default: raw = 1'b0;
        endcase
        return raw ^ cond[0];
    endfunction

endpackage

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [(1<<ADDR_W)*DATA_W-1:0] TABLE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    // Synchronous read; reset lands on the word at address zero.
    always_ff @(posedge clk) begin
        if (rst) data <= TABLE[0 +: DATA_W];
        else     data <= TABLE[int'(addr)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/useq_cond.sv
`timescale 1ns/1ps
module useq_cond import useq_pkg::*; (
    input  logic [COND_W-1:0] cond,
    input  alu_flags_t        flags,
    output logic              ok
);
    always_comb ok = cond_met(cond, flags);
endmodule

// File: rtl/useq_next.sv
`timescale 1ns/1ps
module useq_next import useq_pkg::*; #(
    parameter logic [MAP_DEPTH*UADDR_W-1:0] MAP_TABLE = '0
) (
    input  logic [UADDR_W-1:0] upc,
    input  seq_op_e            op,
    input  logic               ok,
    input  logic [UADDR_W-1:0] target,
    input  logic [OPC_W-1:0]   opc_in,
    output logic [UADDR_W-1:0] nxt,
    output logic               load_ir
);
    logic [UADDR_W-1:0] mapped;

    always_comb mapped = MAP_TABLE[int'(opc_in)*UADDR_W +: UADDR_W];

    always_comb begin
        nxt     = upc + 1'b1;
        load_ir = 1'b0;
        if (ok) begin
            unique case (op)
                SQ_FETCH: begin
                    nxt     = mapped;
                    load_ir = 1'b1;
                end
                SQ_JUMP:    nxt = target;
                SQ_RESTART: nxt = '0;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/useq_top.sv
`timescale 1ns/1ps
module useq_top import useq_pkg::*; #(
    parameter logic [MAP_DEPTH*UADDR_W-1:0]     MAP_TABLE    = '0,
    parameter logic [USTORE_DEPTH*UWORD_W-1:0]  USTORE_TABLE = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [INSTR_W-1:0]  instr_byte,
    input  logic [FLAG_W-1:0]   alu_flags,
    output logic [UWORD_W-1:0]  ctrl_word,
    output logic [UADDR_W-1:0]  upc,
    output logic                ip_inc,
    output logic [OPC_W-1:0]    opcode,
    output logic [PRM_W-1:0]    param,
    output logic [SEL_W-1:0]    sel_a,
    output logic [SEL_W-1:0]    sel_b
);
    logic [UADDR_W-1:0] upc_q;
    logic [UADDR_W-1:0] nxt;
    logic [INSTR_W-1:0] ir_q;
    logic [UWORD_W-1:0] word_raw;
    uword_t             cur_word;
    logic               cond_ok;
    logic               load_ir;

    // Micro store is addressed by the next address, so its output
    // register always holds the word for the current counter value.
    useq_rom #(
        .ADDR_W (UADDR_W),
        .DATA_W (UWORD_W),
        .TABLE  (USTORE_TABLE)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .addr (nxt),
        .data (word_raw)
    );

    always_comb cur_word = uword_t'(word_raw);

    useq_cond u_cond (
        .cond  (cur_word.cond),
        .flags (alu_flags_t'(alu_flags)),
        .ok    (cond_ok)
    );

    useq_next #(
        .MAP_TABLE (MAP_TABLE)
    ) u_next (
        .upc     (upc_q),
        .op      (cur_word.op),
        .ok      (cond_ok),
        .target  (cur_word.target),
        .opc_in  (instr_byte[INSTR_W-1 -: OPC_W]),
        .nxt     (nxt),
        .load_ir (load_ir)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upc_q <= '0;
            ir_q  <= '0;
        end else begin
            upc_q <= nxt;
            if (load_ir) ir_q <= instr_byte;
        end
    end

    always_comb begin
        ctrl_word = {cur_word.op, cur_word.cond, cur_word.target,
                     cond_ok ? cur_word.ctl : {CTL_W{1'b0}}};
        upc       = upc_q;
        ip_inc    = load_ir;
        opcode    = ir_q[INSTR_W-1 -: OPC_W];
        param     = ir_q[PRM_W-1:0];
        sel_a     = param[PRM_W-1 -: SEL_W];
        sel_b     = param[SEL_W-1:0];
    end
endmodule

// File: rtl/useq_chk.sv
`timescale 1ns/1ps
module useq_chk import useq_pkg::*; (
    input logic               clk,
    input logic               rst,
    input logic [UADDR_W-1:0] upc,
    input logic [OPC_W-1:0]   opcode,
    input logic               ip_inc,
    input logic [UWORD_W-1:0] ctrl_word,
    input logic [INSTR_W-1:0] instr_byte,
    input logic               cond_ok
);
    seq_op_e            op;
    logic [UADDR_W-1:0] tgt;

    always_comb begin
        op  = seq_op_e'(ctrl_word[UWORD_W-1 -: 2]);
        tgt = ctrl_word[CTL_W +: UADDR_W];
    end

    AST_RST_HOME: assert property (@(posedge clk)
        rst |=> (upc == '0 && opcode == '0)); // R1

    AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
        (cond_ok && op == SQ_STEP) |=> upc == UADDR_W'($past(upc) + 1'b1)); // R2

    AST_FETCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cond_ok && op == SQ_FETCH) |=> opcode == $past(instr_byte[INSTR_W-1 -: OPC_W])); // R3

    AST_JUMP_TGT: assert property (@(posedge clk) disable iff (rst)
        (cond_ok && op == SQ_JUMP) |=> upc == $past(tgt)); // R4

    AST_RESTART_HOME: assert property (@(posedge clk) disable iff (rst)
        (cond_ok && op == SQ_RESTART) |=> upc == '0); // R5

    AST_FALSE_GATED: assert property (@(posedge clk) disable iff (rst)
        !cond_ok |-> (ctrl_word[CTL_W-1:0] == '0 && !ip_inc)); // R7

    AST_FALSE_ADV: assert property (@(posedge clk) disable iff (rst)
        !cond_ok |=> (upc == UADDR_W'($past(upc) + 1'b1) && $stable(opcode))); // R7
endmodule

bind useq_top useq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .upc        (upc),
    .opcode     (opcode),
    .ip_inc     (ip_inc),
    .ctrl_word  (ctrl_word),
    .instr_byte (instr_byte),
    .cond_ok    (cond_ok)
);

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb;

    function automatic logic [31:0] mk(logic [1:0] op, logic [3:0] cnd,
                                       logic [7:0] tgt, logic [7:0] a);
        return {op, cnd, tgt, 10'h2A5, a};
    endfunction

    function automatic logic [8191:0] build_store();
        logic [8191:0] s;
        s = '0;
        for (int a = 0; a < 256; a++) begin
            logic [31:0] w;
            logic [7:0]  ad;
            ad = 8'(a);
            case (ad)
                8'h00: w = mk(2'b01, 4'b0000, 8'h00, ad);
                8'h04: w = mk(2'b11, 4'b0000, 8'h00, ad);
                8'h11: w = mk(2'b00, 4'b0011, 8'h00, ad);
                8'h12: w = mk(2'b11, 4'b0000, 8'h00, ad);
                8'h20: w = mk(2'b10, 4'b0010, 8'h28, ad);
                8'h21: w = mk(2'b11, 4'b0000, 8'h00, ad);
                8'h28: w = mk(2'b01, 4'b0000, 8'h00, ad);
                8'h30: w = mk(2'b00, 4'b0100, 8'h00, ad);
                8'h31: w = mk(2'b11, 4'b0000, 8'h00, ad);
                8'h40: w = mk(2'b01, 4'b1000, 8'h00, ad);
                8'h41: w = mk(2'b11, 4'b0000, 8'h00, ad);
                8'hF0: w = mk(2'b10, 4'b0000, 8'hFE, ad);
                8'hFE: w = mk(2'b00, 4'b1010, 8'h00, ad);
                default: w = mk(2'b00, 4'b0000, 8'h00, ad);
            endcase
            s[a*32 +: 32] = w;
        end
        return s;
    endfunction

    function automatic logic [127:0] build_map();
        logic [127:0] m;
        m = '0;
        for (int k = 0; k < 16; k++)
            m[k*8 +: 8] = (k == 0) ? 8'h04 : {4'(k), 4'h0};
        return m;
    endfunction

    localparam logic [8191:0] TB_STORE = build_store();
    localparam logic [127:0]  TB_MAP   = build_map();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  instr_byte = '0;
    logic [3:0]  alu_flags  = '0;
    logic [31:0] ctrl_word;
    logic [7:0]  upc;
    logic        ip_inc;
    logic [3:0]  opcode, param;
    logic [1:0]  sel_a, sel_b;

    always #2 clk = ~clk;

    useq_top #(
        .MAP_TABLE    (TB_MAP),
        .USTORE_TABLE (TB_STORE)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .instr_byte (instr_byte),
        .alu_flags  (alu_flags),
        .ctrl_word  (ctrl_word),
        .upc        (upc),
        .ip_inc     (ip_inc),
        .opcode     (opcode),
        .param      (param),
        .sel_a      (sel_a),
        .sel_b      (sel_b)
    );

    typedef struct {
        logic [7:0] upc;
        logic       gate;
        logic       ipinc;
        logic [3:0] opc;
        logic [3:0] prm;
        string      rq;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    function automatic logic [31:0] word_at(logic [7:0] a);
        return TB_STORE[int'(a)*32 +: 32];
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Monitor: compares mid-cycle against the oldest pending expectation.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [31:0] ew;
            e  = q.pop_front();
            ew = word_at(e.upc);
            if (!e.gate) ew[17:0] = '0;
            chk(e.rq, "upc",       32'(upc),    32'(e.upc));
            chk(e.rq, "ctrl_word", ctrl_word,   ew);
            chk(e.rq, "ip_inc",    32'(ip_inc), 32'(e.ipinc));
            chk(e.rq, "opcode",    32'(opcode), 32'(e.opc));
            chk(e.rq, "param",     32'(param),  32'(e.prm));
            chk(e.rq, "sel_a",     32'(sel_a),  32'(e.prm[3:2]));
            chk(e.rq, "sel_b",     32'(sel_b),  32'(e.prm[1:0]));
        end
    end

    // Driver: applies one cycle of stimulus and queues what that cycle must show.
    task automatic cyc(logic [7:0] ib, logic [3:0] fl, logic [7:0] e_upc,
                       logic e_gate, logic e_ip, logic [3:0] e_opc,
                       logic [3:0] e_prm, string rq);
        exp_t e;
        instr_byte = ib;
        alu_flags  = fl;
        e.upc = e_upc; e.gate = e_gate; e.ipinc = e_ip;
        e.opc = e_opc; e.prm = e_prm; e.rq = rq;
        q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // flags: bit0 zero, bit1 carry, bit2 overflow, bit3 negative
        cyc(8'h1B, 4'b0000, 8'h00, 1, 1, 4'h0, 4'h0, "R1 R3");
        cyc(8'h00, 4'b0000, 8'h10, 1, 0, 4'h1, 4'hB, "R8");
        cyc(8'h00, 4'b0000, 8'h11, 1, 0, 4'h1, 4'hB, "R6");
        cyc(8'h00, 4'b0000, 8'h12, 1, 0, 4'h1, 4'hB, "R5");
        cyc(8'h25, 4'b0000, 8'h00, 1, 1, 4'h1, 4'hB, "R3");
        cyc(8'h00, 4'b0001, 8'h20, 1, 0, 4'h2, 4'h5, "R4");
        cyc(8'h36, 4'b0000, 8'h28, 1, 1, 4'h2, 4'h5, "R3");
        cyc(8'h00, 4'b0000, 8'h30, 0, 0, 4'h3, 4'h6, "R7");
        cyc(8'h00, 4'b0000, 8'h31, 1, 0, 4'h3, 4'h6, "R5");
        cyc(8'h27, 4'b0000, 8'h00, 1, 1, 4'h3, 4'h6, "R3");
        cyc(8'h00, 4'b0000, 8'h20, 0, 0, 4'h2, 4'h7, "R7");
        cyc(8'h00, 4'b0000, 8'h21, 1, 0, 4'h2, 4'h7, "R2");
        cyc(8'h4C, 4'b0000, 8'h00, 1, 1, 4'h2, 4'h7, "R3");
        cyc(8'h99, 4'b0000, 8'h40, 0, 0, 4'h4, 4'hC, "R7");
        cyc(8'h00, 4'b0000, 8'h41, 1, 0, 4'h4, 4'hC, "R7");
        cyc(8'h4C, 4'b0000, 8'h00, 1, 1, 4'h4, 4'hC, "R3");
        cyc(8'hF3, 4'b1000, 8'h40, 1, 1, 4'h4, 4'hC, "R6");
        cyc(8'h00, 4'b0000, 8'hF0, 1, 0, 4'hF, 4'h3, "R4");
        cyc(8'h00, 4'b1111, 8'hFE, 0, 0, 4'hF, 4'h3, "R6");
        cyc(8'h00, 4'b0000, 8'hFF, 1, 0, 4'hF, 4'h3, "R2");
        cyc(8'h0A, 4'b0000, 8'h00, 1, 1, 4'hF, 4'h3, "R2");
        cyc(8'h00, 4'b0000, 8'h04, 1, 0, 4'h0, 4'hA, "R3");
        cyc(8'h13, 4'b0000, 8'h00, 1, 1, 4'h0, 4'hA, "R5");
        // mid-program reset while the fetch above is in flight
        rst = 1'b1;
        instr_byte = 8'h00;
        @(posedge clk);
        #1;
        rst = 1'b0;
        cyc(8'h00, 4'b0000, 8'h00, 1, 1, 4'h0, 4'h0, "R1");
        while (q.size() > 0) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule